// File: doc/BRIEF.md
# Accumulator CPU Control Core

This block is a small 8-bit processor built around one accumulator. It reads its program and data from a byte-wide external memory and writes results back to that memory. Every instruction starts with an opcode byte. Most opcodes are followed by one operand byte. The operand is used in one of three ways: as a constant, as the address of a data byte, or as the address of a pointer byte that holds the final address. A multi-cycle sequencer steps through fetch, operand read, pointer read, execute and store phases. It owns the program counter, the address pointer, the instruction register, the accumulator and two condition flags. The arithmetic and shift unit is a separate module instantiated inside the core.

The external data bus is split into an input, an output and an output-enable. A pad ring or the bench joins these into one bidirectional bus. Only the low seven address bits leave the block. A halt input freezes the core when it next tries to fetch an opcode, and the core stays frozen for as long as the input is held.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_ni` is low, the accumulator, pointer, program counter, instruction register and flags all clear to zero, and `we_o` and `data_oe_o` stay low. After reset is released, the first opcode is read from address 0x00.
- R2: The following opcodes are one byte long: 0x00 and every code above 0x24. Codes above 0x24 behave exactly like 0x00, which does nothing. Every opcode from 0x01 to 0x24 is followed by one operand byte.
- R3: Opcodes 0x01 to 0x1A, except 0x03 and 0x04, form pairs. The odd code takes the operand as a constant. The even code reads the byte at the operand address. Each pair computes a new accumulator value as follows: 0x01/0x02 load; 0x05/0x06 add; 0x07/0x08 subtract the operand from the accumulator; 0x09/0x0A AND; 0x0B/0x0C OR; 0x0D/0x0E XOR. All arithmetic is modulo 256.
- R4: The shift pairs are 0x0F/0x10 (logical left), 0x11/0x12 (logical right), 0x13/0x14 (arithmetic left, same as logical left), 0x15/0x16 (arithmetic right, sign-filling), 0x17/0x18 (rotate left) and 0x19/0x1A (rotate right). A shift amount of 8 or more gives 0x00 for the logical and left shifts, and all copies of bit 7 for the arithmetic right shift. Rotates use the amount modulo 8.
- R5: The Z flag is set when the result is zero. The N flag is a copy of result bit 7. Both flags are written only by the load and ALU opcodes (R3, R4). Stores, jumps, branches and one-byte opcodes leave them unchanged.
- R6: Opcode 0x03 stores the accumulator at the operand address. Opcode 0x04 first reads a pointer byte at the operand address, then stores the accumulator at the address held in that pointer.
- R7: Opcode 0x1B loads the program counter with the operand. Opcode 0x1C loads it with the byte stored at the operand address.
- R8: The branch pairs, direct then indirect, are: 0x1D/0x1E taken when Z is clear; 0x1F/0x20 taken when Z is set; 0x21/0x22 taken when N is clear; 0x23/0x24 taken when N is set. A taken branch jumps like R7. A branch that is not taken continues at the byte after its operand.
- R9: `addr_o` carries bits [6:0] of the program counter during opcode and operand reads, and bits [6:0] of the pointer register in all other cycles. The external memory therefore holds 128 bytes.
- R10: A store drives the accumulator on `data_o` with `data_oe_o` high for two consecutive cycles. `we_o` is high only in the first of these cycles, so the data is still valid when `we_o` falls. `data_oe_o` is low at all other times.
- R11: While `halt_i` is high and the core is at an opcode fetch, the core does not advance: the address stays constant and no store occurs. When `halt_i` drops, execution resumes at the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Freeze at the next opcode fetch |
| data_i | input | 8 | Read data from external memory |
| data_o | output | 8 | Store data (the accumulator) |
| data_oe_o | output | 1 | Output enable for the data bus |
| addr_o | output | 7 | Memory address |
| we_o | output | 1 | Write strobe, first store cycle only |

## Verification
Randomly generated programs mix all operand modes, ALU opcodes with both small and large shift amounts, pointer stores, one-byte and unknown opcodes, and forward branches that either skip or fall through the following instruction. A model of the instruction set inside the bench predicts the sequence of store addresses and data, so any wrong result, flag, operand mode or branch decision shows up as a trace mismatch. A directed program uses fixed expected values to separate boundary behaviour: a sign-filling shift by 9, a logical shift by 8, a rotate by 11, a taken branch on Z, an N flag kept across a store, and a pointer jump that wraps the loop. One random run asserts halt mid-program to check that the address freezes and that the store trace continues unchanged afterwards.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int CCR_W = 2;
  localparam int CCR_Z = 0;
  localparam int CCR_N = 1;

  typedef enum logic [3:0] {
    ALU_PASS_B, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_LSL, ALU_LSR, ALU_ASL, ALU_ASR, ALU_ROL, ALU_ROR
  } alu_op_e;

  typedef enum logic [1:0] {AM_NONE, AM_IMM, AM_DIR, AM_IND} amode_e;

  typedef enum logic [2:0] {IC_NOP, IC_ALU, IC_STORE, IC_JUMP, IC_BRANCH} iclass_e;

  typedef enum logic [1:0] {CC_ZC, CC_ZS, CC_NC, CC_NS} cond_e;

  typedef struct packed {
    iclass_e cls;
    amode_e  mode;
    alu_op_e op;
    cond_e   cond;
  } dec_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPND, ST_PTR, ST_EXEC, ST_WR, ST_WR_END
  } state_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic [CCR_W-1:0] flags_o
);
  localparam int SHW = $clog2(W);

  logic           big;
  logic [SHW-1:0] amt;

  assign big = |b_i[W-1:SHW];
  assign amt = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      ALU_PASS_B: res_o = b_i;
      ALU_ADD:    res_o = a_i + b_i;
      ALU_SUB:    res_o = a_i - b_i;
      ALU_AND:    res_o = a_i & b_i;
      ALU_OR:     res_o = a_i | b_i;
      ALU_XOR:    res_o = a_i ^ b_i;
      ALU_LSL,
      ALU_ASL:    res_o = big ? '0 : (a_i << amt);
      ALU_LSR:    res_o = big ? '0 : (a_i >> amt);
      ALU_ASR:    res_o = big ? {W{a_i[W-1]}} : W'($signed(a_i) >>> amt);
      ALU_ROL:    res_o = (a_i << amt) | (a_i >> (W - int'(amt)));
      ALU_ROR:    res_o = (a_i >> amt) | (a_i << (W - int'(amt)));
      default:    res_o = b_i;
    endcase
  end

  always_comb begin
    flags_o        = '0;
    flags_o[CCR_Z] = (res_o == '0);
    flags_o[CCR_N] = res_o[W-1];
  end

endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opc_i,
  output dec_t       dec_o
);
  int code;
  int idx;
  int jdx;

  always_comb begin
    code  = int'(opc_i);
    idx   = (code - 1) / 2;
    jdx   = code - 'h1B;
    dec_o = '{cls: IC_NOP, mode: AM_NONE, op: ALU_PASS_B, cond: CC_ZC};
    if (code >= 'h01 && code <= 'h1A) begin
      if (idx == 1) begin
        dec_o.cls  = IC_STORE;
        dec_o.mode = opc_i[0] ? AM_DIR : AM_IND;
      end else begin
        dec_o.cls  = IC_ALU;
        dec_o.mode = opc_i[0] ? AM_IMM : AM_DIR;
        dec_o.op   = (idx == 0) ? ALU_PASS_B : alu_op_e'(idx - 1);
      end
    end else if (code >= 'h1B && code <= 'h24) begin
      dec_o.mode = (jdx % 2 == 1) ? AM_IND : AM_DIR;
      dec_o.cls  = (jdx < 2) ? IC_JUMP : IC_BRANCH;
      dec_o.cond = (jdx < 2) ? CC_ZC : cond_e'((jdx - 2) / 2);
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIN_AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [PIN_AW-1:0] addr_o,
  output logic              we_o
);
  state_e              state_q;
  logic [DATA_W-1:0]   a_q, pc_q, ir_q;
  logic [PIN_AW-1:0]   m_q;
  logic [CCR_W-1:0]    ccr_q;

  logic [DATA_W-1:0]   dec_src;
  dec_t                dec;
  logic [DATA_W-1:0]   alu_res;
  logic [CCR_W-1:0]    alu_flags;
  logic                cond_ok;
  logic                take;

  // opcode byte is on the bus during fetch, held in IR afterwards
  assign dec_src = (state_q == ST_FETCH) ? data_i : ir_q;

  acc_decode u_dec (
    .opc_i (dec_src[7:0]),
    .dec_o (dec)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op_i    (dec.op),
    .a_i     (a_q),
    .b_i     (data_i),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  always_comb begin
    unique case (dec.cond)
      CC_ZC:   cond_ok = !ccr_q[CCR_Z];
      CC_ZS:   cond_ok =  ccr_q[CCR_Z];
      CC_NC:   cond_ok = !ccr_q[CCR_N];
      default: cond_ok =  ccr_q[CCR_N];
    endcase
    take = (dec.cls == IC_JUMP) || cond_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      a_q     <= '0;
      m_q     <= '0;
      pc_q    <= '0;
      ir_q    <= '0;
      ccr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          if (!halt_i) begin
            ir_q    <= data_i;
            pc_q    <= pc_q + 1'b1;
            state_q <= (dec.cls == IC_NOP) ? ST_FETCH : ST_OPND;
          end
        end
        ST_OPND: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_FETCH;
          unique case (dec.cls)
            IC_ALU: begin
              if (dec.mode == AM_IMM) begin
                a_q   <= alu_res;
                ccr_q <= alu_flags;
              end else begin
                m_q     <= data_i[PIN_AW-1:0];
                state_q <= ST_EXEC;
              end
            end
            IC_STORE: begin
              m_q     <= data_i[PIN_AW-1:0];
              state_q <= (dec.mode == AM_DIR) ? ST_WR : ST_PTR;
            end
            IC_JUMP, IC_BRANCH: begin
              if (take) begin
                if (dec.mode == AM_DIR) begin
                  pc_q <= data_i;
                end else begin
                  m_q     <= data_i[PIN_AW-1:0];
                  state_q <= ST_PTR;
                end
              end
            end
            default: ;
          endcase
        end
        ST_PTR: begin
          if (dec.cls == IC_STORE) begin
            m_q     <= data_i[PIN_AW-1:0];
            state_q <= ST_WR;
          end else begin
            pc_q    <= data_i;
            state_q <= ST_FETCH;
          end
        end
        ST_EXEC: begin
          a_q     <= alu_res;
          ccr_q   <= alu_flags;
          state_q <= ST_FETCH;
        end
        ST_WR:     state_q <= ST_WR_END;
        ST_WR_END: state_q <= ST_FETCH;
        default:   state_q <= ST_FETCH;
      endcase
    end
  end

  assign addr_o    = (state_q == ST_FETCH || state_q == ST_OPND) ? pc_q[PIN_AW-1:0] : m_q;
  assign we_o      = (state_q == ST_WR);
  assign data_oe_o = (state_q == ST_WR) || (state_q == ST_WR_END);
  assign data_o    = a_q;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic              we_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input state_e            state_q,
  input logic [DATA_W-1:0] pc_q,
  input logic [CCR_W-1:0]  ccr_q
);

  p_we_oe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> data_oe_o);

  p_we_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (!we_o && data_oe_o));

  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> $stable(data_o));

  p_halt_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && halt_i) |=> (state_q == ST_FETCH && $stable(pc_q)));

  p_fetch_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && !halt_i) |=> (pc_q == $past(pc_q) + 1'b1));

  p_ccr_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR || state_q == ST_PTR) |=> $stable(ccr_q));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .halt_i    (halt_i),
  .we_o      (we_o),
  .data_oe_o (data_oe_o),
  .data_o    (data_o),
  .state_q   (state_q),
  .pc_q      (pc_q),
  .ccr_q     (ccr_q)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       halt_i;
  logic [7:0] data_i, data_o;
  logic       data_oe_o, we_o;
  logic [6:0] addr_o;

  logic [7:0] mem [128];
  logic [7:0] rm  [128];
  logic [7:0] ra, rpc;
  logic       rz, rn;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  assign data_i = mem[addr_o];
  always @(negedge clk_i) if (we_o) mem[addr_o] <= data_o;

  acc_cpu_core i_acc_cpu_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .data_i    (data_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .addr_o    (addr_o),
    .we_o      (we_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference semantics taken from the requirement list
  function automatic logic [7:0] ref_alu(input int idx, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    case (idx)
      0:  r = b;
      2:  r = a + b;
      3:  r = a - b;
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7, 9: r = (b >= 8) ? 8'h00 : (a << b);
      8:  r = (b >= 8) ? 8'h00 : (a >> b);
      10: begin
        r = a;
        for (int i = 0; i < ((b >= 8) ? 8 : int'(b)); i++) r = {r[7], r[7:1]};
      end
      11: begin
        r = a;
        for (int i = 0; i < int'(b % 8); i++) r = {r[6:0], r[7]};
      end
      default: begin
        r = a;
        for (int i = 0; i < int'(b % 8); i++) r = {r[0], r[7:1]};
      end
    endcase
    return r;
  endfunction

  task automatic model_store(output logic [6:0] sa, output logic [7:0] sd);
    logic [7:0] op, o, ea;
    int idx, j;
    bit done = 0, tk;
    for (int g = 0; g < 4000 && !done; g++) begin
      op = rm[rpc[6:0]]; rpc = rpc + 1;
      if (op >= 8'h01 && op <= 8'h24) begin
        o = rm[rpc[6:0]]; rpc = rpc + 1;
        if (op <= 8'h1A) begin
          idx = (int'(op) - 1) / 2;
          if (idx == 1) begin
            ea = (op == 8'h03) ? o : rm[o[6:0]];
            sa = ea[6:0]; sd = ra; done = 1;
            rm[ea[6:0]] = ra;
          end else begin
            ra = ref_alu(idx, ra, op[0] ? o : rm[o[6:0]]);
            rz = (ra == 0); rn = ra[7];
          end
        end else begin
          j = int'(op) - 'h1B;
          case ((j - 2) / 2)
            0: tk = !rz;
            1: tk = rz;
            2: tk = !rn;
            default: tk = rn;
          endcase
          if (j < 2) tk = 1;
          if (tk) rpc = (j % 2 == 1) ? rm[o[6:0]] : o;
        end
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; halt_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", "we during reset", we_o, 0);
    chk("R1", "oe during reset", data_oe_o, 0);
    rst_ni = 1'b1;
    chk("R1", "first fetch address", addr_o, 0);
    ra = 0; rpc = 0; rz = 0; rn = 0;
    for (int i = 0; i < 128; i++) rm[i] = mem[i];
  endtask

  task automatic wait_store(output logic [6:0] a, output logic [7:0] d);
    int c = 0;
    @(negedge clk_i);
    while (!we_o && c < 600) begin @(negedge clk_i); c++; end
    if (!we_o) chk("R6", "store timeout", 0, 1);
    a = addr_o; d = data_o;
    chk("R10", "oe with we", data_oe_o, 1);
    @(negedge clk_i);
    chk("R10", "we second cycle", we_o, 0);
    chk("R10", "oe second cycle", data_oe_o, 1);
    chk("R10", "data held", data_o, d);
  endtask

  task automatic halt_seq();
    logic [6:0] a0;
    bit moved = 0, wrote = 0;
    halt_i = 1'b1;
    repeat (8) @(negedge clk_i);
    a0 = addr_o;
    repeat (20) begin
      @(negedge clk_i);
      if (addr_o != a0) moved = 1;
      if (we_o) wrote = 1;
    end
    chk("R11", "address moved while halted", moved, 0);
    chk("R11", "store while halted", wrote, 0);
    halt_i = 1'b0;
  endtask

  task automatic run_cmp(input int n, input int halt_at);
    logic [6:0] ea, a;
    logic [7:0] ed, d;
    do_reset();
    for (int k = 0; k < n; k++) begin
      model_store(ea, ed);
      wait_store(a, d);
      chk("R9", "store address", a, ea);
      chk("R3", "store data", d, ed);
      if (k == halt_at) halt_seq();
    end
  endtask

  task automatic emit_alu(inout logic [7:0] pc);
    int k, idx;
    bit imm;
    k = $urandom % 12;
    idx = (k == 0) ? 0 : k + 1;
    imm = $urandom % 2;
    mem[pc[6:0]] = 8'(2 * idx + (imm ? 1 : 2));
    if (imm) mem[pc[6:0] + 1] = (idx >= 7 && $urandom % 2 == 1) ? 8'($urandom % 12) : 8'($urandom);
    else     mem[pc[6:0] + 1] = 8'(8'h60 + $urandom % 32);
    pc = pc + 2;
  endtask

  task automatic gen_prog();
    logic [7:0] pc, slot, tgt;
    logic [7:0] one [4] = '{8'h00, 8'h25, 8'hFF, 8'h80};
    int r, j;
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    pc = 0; slot = 8'h50;
    while (pc < 8'h40) begin
      r = $urandom % 10;
      if (r < 5) emit_alu(pc);
      else if (r < 7) begin
        if ($urandom % 2 == 1 || slot >= 8'h5E) begin
          mem[pc[6:0]] = 8'h03; mem[pc[6:0] + 1] = 8'(8'h70 + $urandom % 16);
        end else begin
          mem[pc[6:0]] = 8'h04; mem[pc[6:0] + 1] = slot;
          mem[slot[6:0]] = 8'(8'h70 + $urandom % 16); slot = slot + 1;
        end
        pc = pc + 2;
      end else if (r == 7) begin
        mem[pc[6:0]] = one[$urandom % 4]; pc = pc + 1;
      end else begin
        j = $urandom % 10;
        if (slot >= 8'h5E) j = j & ~1;
        tgt = pc + 4;
        mem[pc[6:0]] = 8'(8'h1B + j);
        if (j % 2 == 0) mem[pc[6:0] + 1] = tgt;
        else begin
          mem[pc[6:0] + 1] = slot; mem[slot[6:0]] = tgt; slot = slot + 1;
        end
        pc = pc + 2;
        emit_alu(pc);
      end
    end
    mem[pc[6:0]] = 8'h03; mem[pc[6:0] + 1] = 8'h7F;
    mem[pc[6:0] + 2] = 8'h1B; mem[pc[6:0] + 3] = 8'h00;
  endtask

  task automatic directed();
    logic [7:0] prog [32] = '{
      8'h01, 8'h81, 8'h15, 8'h09, 8'h03, 8'h70, 8'h0F, 8'h08,
      8'h03, 8'h71, 8'h1F, 8'h10, 8'h01, 8'h55, 8'h03, 8'h72,
      8'h01, 8'h96, 8'h17, 8'h0B, 8'h03, 8'h73, 8'hFF, 8'h04,
      8'h50, 8'h23, 8'h1D, 8'h03, 8'h75, 8'h1C, 8'h51, 8'h00};
    logic [6:0] a;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    for (int i = 0; i < 32; i++) mem[i] = prog[i];
    mem[8'h50] = 8'h74; mem[8'h51] = 8'h00;
    do_reset();
    for (int it = 0; it < 2; it++) begin
      wait_store(a, d);
      chk("R4", "asr by 9 addr", a, 7'h70); chk("R4", "asr by 9 sign fill", d, 8'hFF);
      wait_store(a, d);
      chk("R4", "lsl by 8 addr", a, 7'h71); chk("R4", "lsl by 8 zero", d, 8'h00);
      wait_store(a, d);
      chk("R8", "beq taken skips store", a, 7'h73); chk("R4", "rotate by 11", d, 8'hB4);
      wait_store(a, d);
      chk("R6", "pointer store addr", a, 7'h74); chk("R6", "pointer store data", d, 8'hB4);
    end
    chk("R5", "N kept across store, bmi taken", mem[8'h75], 8'h00);
    chk("R7", "indirect jump loop repeated", mem[8'h72], 8'h00);
  endtask

  initial begin
    int seed_dummy;
    bit wd_hit = 0;
    seed_dummy = $urandom(32'h5EED_0A11);
    rst_ni = 1'b0; halt_i = 1'b0;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    fork
      begin
        directed();
        for (int p = 0; p < 6; p++) begin
          gen_prog();
          run_cmp(30, (p == 1) ? 5 : -1);
        end
      end
      begin
        repeat (150000) @(posedge clk_i);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) chk("R1", "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule